// File: doc/BRIEF.md
# Bipolar AMI Line Encoder with Eight-Zero Substitution

This block turns a serial bit stream into a three-level bipolar line code. One bit enters with each valid strobe. Once eight bits are buffered, each later strobe yields one ternary symbol on a 2-bit output code. In the default mode, marks (1 bits) alternate in polarity and spaces (0 bits) are sent as zero level. A mode input swaps these roles so that spaces alternate and marks are sent as zero level.

An optional substitution keeps the line active through long runs of spaces. In the default mode with substitution enabled, any run of eight consecutive 0 bits is sent as the symbol group zero, zero, zero, V, B, zero, V, B. A V pulse repeats the polarity of the most recent pulse. A B pulse takes the opposite polarity. The encoder holds the eight most recent bits, so it sees a complete run before it sends the first symbol of that run. This gives a fixed delay of eight strobes.

Top module: `bipolar_line_encoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0 and `out_sym` is 2'b00.
- R2: The first eight strobes after reset produce no output. Strobe number n (counting from 0) with n of at least 8 sets `out_valid` high on the next cycle, and `out_sym` then carries the symbol for bit n-8.
- R3: The symbol code is 2'b01 for a positive pulse, 2'b11 for a negative pulse and 2'b00 for zero level. After reset the last pulse is taken as negative, so the first pulse sent is 2'b01.
- R4: With `pseudo_mode` low, a 0 bit is sent as 2'b00. A 1 bit is sent as a pulse whose polarity is opposite to the most recent pulse.
- R5: With `pseudo_mode` high, a 1 bit is sent as 2'b00. A 0 bit is sent as a pulse whose polarity is opposite to the most recent pulse.
- R6: With `subst_en` high and `pseudo_mode` low, eight consecutive 0 bits are sent in order as 0,0,0,V,B,0,V,B. V has the same polarity as the most recent pulse and B has the opposite polarity. Every V and B counts as the most recent pulse for whatever follows it.
- R7: After a substitution, the next pulse has the polarity it would have had if the run had been sent without substitution.
- R8: Runs are counted without overlap. Detection restarts with the bit after a substituted group. So 16 zeros give two substitutions, and 15 zeros give one substitution followed by seven zero-level symbols.
- R9: With `subst_en` low, or with `pseudo_mode` high, no substitution occurs and runs of 0 bits follow R4 or R5.
- R10: A cycle without a strobe gives `out_valid` 0 and `out_sym` 2'b00, and it leaves the buffered bits and the polarity unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: `in_bit` is accepted this cycle |
| in_bit | input | 1 | Serial data bit |
| pseudo_mode | input | 1 | 1 selects the variant where 0 bits alternate |
| subst_en | input | 1 | 1 enables eight-zero substitution |
| out_valid | output | 1 | A symbol is present on `out_sym` |
| out_sym | output | 2 | Ternary symbol: 01 positive, 11 negative, 00 zero |

## Verification
The hardest cases to reach are zero runs that sit next to the limits of the window. These include a run that starts right after reset, before any pulse has set the polarity, so the first V is negative. They also include runs of 15 and 16 zeros, where the non-overlap rule decides whether a second group is sent. A directed stream places these runs at chosen offsets. A sweep then sends every 8-bit value followed by three zeros, so zero runs of every length cross value boundaries at every phase of the window. That sweep runs in both modes, with idle gaps between strobes.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int RUN_LEN = 8;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_POS  = 2'b01,
    SYM_NEG  = 2'b11
  } tsym_e;

  // what the current output slot must carry
  typedef enum logic [1:0] {
    K_DATA = 2'd0,
    K_ZERO = 2'd1,
    K_VIOL = 2'd2,
    K_BIP  = 2'd3
  } kind_e;

  // slot contents of the substitution group 0,0,0,V,B,0,V,B
  function automatic kind_e slot_kind(input int unsigned pos);
    case (pos)
      3, 6:    slot_kind = K_VIOL;
      4, 7:    slot_kind = K_BIP;
      default: slot_kind = K_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/tl_window.sv
module tl_window #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic bit_in,
  output logic bit_out,
  output logic all_zero,
  output logic full
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] sr;
  logic [CW-1:0]    fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      fill <= '0;
    end else if (shift_en) begin
      sr <= {sr[DEPTH-2:0], bit_in};
      if (fill != CW'(DEPTH)) fill <= fill + 1'b1;
    end
  end

  assign bit_out  = sr[DEPTH-1];
  assign all_zero = (sr == '0);
  assign full     = (fill == CW'(DEPTH));

  // R2: the fill count never passes the window depth
  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));
  // R2: once the window is full it stays full until reset
  assert_full_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    full |=> full);
endmodule

// File: rtl/tl_subst.sv
module tl_subst
  import tl_pkg::*;
#(
  parameter int RUN = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  step,
  input  logic  start_ok,
  output kind_e kind
);
  localparam int PW = $clog2(RUN);

  logic [PW-1:0] pos;
  logic          active;

  assign active = (pos != '0);

  always_comb begin
    if (active)        kind = slot_kind(32'(pos));
    else if (start_ok) kind = slot_kind(0);
    else               kind = K_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (step && (active || start_ok)) begin
      pos <= (pos == PW'(RUN - 1)) ? '0 : pos + 1'b1;
    end
  end

  // R10: without a strobe the group position does not move
  assert_pos_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pos));
  // R8: the last slot of a group hands back to fresh detection
  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (step && pos == PW'(RUN - 1)) |=> (pos == '0));
endmodule

// File: rtl/tl_polar.sv
module tl_polar
  import tl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  kind_e      kind,
  input  logic       data_bit,
  input  logic       pseudo,
  output logic       out_valid,
  output logic [1:0] out_sym
);
  logic  last_pos;
  logic  nxt_last;
  tsym_e sym;

  always_comb begin
    nxt_last = last_pos;
    sym      = SYM_ZERO;
    case (kind)
      K_DATA: begin
        if (data_bit ^ pseudo) begin
          sym      = last_pos ? SYM_NEG : SYM_POS;
          nxt_last = ~last_pos;
        end
      end
      K_BIP: begin
        sym      = last_pos ? SYM_NEG : SYM_POS;
        nxt_last = ~last_pos;
      end
      K_VIOL:  sym = last_pos ? SYM_POS : SYM_NEG;
      default: sym = SYM_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pos  <= 1'b0;
      out_valid <= 1'b0;
      out_sym   <= SYM_ZERO;
    end else begin
      out_valid <= step;
      out_sym   <= step ? sym : SYM_ZERO;
      if (step) last_pos <= nxt_last;
    end
  end

  // R3: the unused code 2'b10 never appears
  assert_code_legal_R3: assert property (@(posedge clk) disable iff (rst)
    out_sym != 2'b10);
  // R6: a violation pulse leaves the polarity state alone
  assert_viol_keeps_pol_R6: assert property (@(posedge clk) disable iff (rst)
    (step && kind == K_VIOL) |=> $stable(last_pos));
  // R4: every data pulse flips the polarity state
  assert_mark_flips_R4: assert property (@(posedge clk) disable iff (rst)
    (step && kind == K_DATA && (data_bit ^ pseudo)) |=> (last_pos != $past(last_pos)));
endmodule

// File: rtl/bipolar_line_encoder.sv
module bipolar_line_encoder
  import tl_pkg::*;
#(
  parameter int RUN_LEN = tl_pkg::RUN_LEN
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic       pseudo_mode,
  input  logic       subst_en,
  output logic       out_valid,
  output logic [1:0] out_sym
);
  logic  oldest;
  logic  win_zero;
  logic  win_full;
  logic  step;
  logic  start_ok;
  kind_e kind;

  assign step     = in_valid & win_full;
  assign start_ok = subst_en & ~pseudo_mode & win_zero;

  tl_window #(.DEPTH(RUN_LEN)) u_window (
    .clk      (clk),
    .rst      (rst),
    .shift_en (in_valid),
    .bit_in   (in_bit),
    .bit_out  (oldest),
    .all_zero (win_zero),
    .full     (win_full)
  );

  tl_subst #(.RUN(RUN_LEN)) u_subst (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .start_ok (start_ok),
    .kind     (kind)
  );

  tl_polar u_polar (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .kind      (kind),
    .data_bit  (oldest),
    .pseudo    (pseudo_mode),
    .out_valid (out_valid),
    .out_sym   (out_sym)
  );

  // R2: output appears only on the cycle after a strobe
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
endmodule

// File: tb/test_bipolar_line_encoder.sv
`timescale 1ns/1ps
module test_bipolar_line_encoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       pseudo_mode = 1'b0;
  logic       subst_en = 1'b0;
  logic       out_valid;
  logic [1:0] out_sym;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bipolar_line_encoder i_bipolar_line_encoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .pseudo_mode(pseudo_mode), .subst_en(subst_en),
    .out_valid(out_valid), .out_sym(out_sym)
  );

  localparam logic [63:0] P_MIX = 64'hB5A7_3C19_E2D4_8F61;

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit bitf(input int sel, input int i);
    int v, p;
    case (sel)
      0: bitf = P_MIX[i % 64];
      4: begin
        v = i / 11; p = i % 11;
        bitf = (p < 8) ? bit'((v >> p) & 1) : 1'b0;
      end
      default: begin // directed run layout
        if (i < 8) bitf = 0;
        else if (i == 8 || i == 9 || i == 18 || i == 22 || i == 39) bitf = 1;
        else if (i == 55 || i == 56 || i >= 60) bitf = 1;
        else bitf = 0;
      end
    endcase
  endfunction

  function automatic bit zero8(input int sel, input int k);
    for (int j = 0; j < 8; j++) if (bitf(sel, k + j)) return 0;
    return 1;
  endfunction

  // 0 data, 1 zero, 2 V, 3 B
  function automatic int slotk(input int p);
    if (p == 3 || p == 6) return 2;
    if (p == 4 || p == 7) return 3;
    return 1;
  endfunction

  task automatic run_seg(input int sel, input int len, input bit pm, input bit en,
                         input string tagovr);
    bit last;
    int spos, kd, k;
    bit after, mark;
    logic [1:0] exp;
    string tag;
    @(negedge clk);
    rst = 1; in_valid = 0; pseudo_mode = pm; subst_en = en;
    @(negedge clk);
    check("R1", {1'b0, out_valid}, 2'b00);
    check("R1", out_sym, 2'b00);
    rst = 0;
    @(negedge clk);
    check("R1", {1'b0, out_valid}, 2'b00);
    last = 0; spos = 0; after = 0;
    for (int i = 0; i < len; i++) begin
      in_valid = 1; in_bit = bitf(sel, i);
      @(negedge clk);
      in_valid = 0;
      if (i < 8) begin
        check("R2", {1'b0, out_valid}, 2'b00);
      end else begin
        k = i - 8;
        if (spos != 0) begin
          kd = slotk(spos); spos = (spos + 1) % 8;
        end else if (en && !pm && zero8(sel, k)) begin
          kd = slotk(0); spos = 1;
        end else kd = 0;
        mark = 0;
        case (kd)
          0: begin
            if (bitf(sel, k) ^ pm) begin
              exp = last ? 2'b11 : 2'b01; last = ~last; mark = 1;
            end else exp = 2'b00;
          end
          1: exp = 2'b00;
          2: exp = last ? 2'b01 : 2'b11;
          default: begin exp = last ? 2'b11 : 2'b01; last = ~last; end
        endcase
        if (kd != 0) tag = "R6";
        else if (mark && after) tag = "R7";
        else tag = pm ? "R5" : "R4";
        if (sel == 1 && k >= 23 && k <= 54) tag = "R8";
        if (tagovr != "") tag = tagovr;
        if (kd != 0 && spos == 0) after = 1;
        else if (mark) after = 0;
        check("R2", {1'b0, out_valid}, 2'b01);
        check(tag, out_sym, exp);
        if (sel == 0 && k == 0) check("R3", out_sym, 2'b01);
      end
      if (i % 7 == 6) begin
        @(negedge clk);
        check("R10", {1'b0, out_valid}, 2'b00);
        check("R10", out_sym, 2'b00);
      end
    end
  endtask

  initial begin
    run_seg(0, 56, 0, 1, "");     // plain AMI pattern, no long runs
    run_seg(1, 64, 0, 1, "");     // directed runs: start, 8, 16, 15
    run_seg(1, 64, 1, 1, "R5");   // pseudoternary, substitution ignored
    run_seg(1, 64, 1, 1, "R9");
    run_seg(1, 64, 0, 0, "R9");   // substitution disabled
    run_seg(4, 256 * 11 + 8, 0, 1, ""); // sweep in AMI with substitution
    run_seg(4, 256 * 11 + 8, 1, 0, ""); // sweep in pseudoternary
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R2 watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule